// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block owns the program counter of a small processor and decides, once per advance, where the next instruction comes from. It can step to the following word, take or skip a relative branch guarded by the zero or carry flag, jump to an absolute address, enter a subroutine, or return from one. A call stores the address that follows it on a small hardware stack inside the block, and a return takes the newest stored address back. Nested subroutines therefore unwind in last-in first-out order.

The surrounding core decodes each instruction into a control-flow code, a condition selector, a signed displacement and an absolute target. It presents these together with the current flags and raises the advance strobe when the instruction retires. The block presents the address to fetch next on its output. Address width, displacement width, stack depth and reset address are parameters. The defaults give a 4096-word space, 8-bit displacements and an 8-entry stack.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the PC reads 0x000 and the return stack is empty. A return issued right after reset loads 0x000.
- R2: On a clock edge where `adv_i` is low, neither the PC nor the return stack changes, whatever the other inputs are.
- R3: Flow code 0 (sequential) sets the PC to PC+1, wrapping from 0xFFF to 0x000. Unused flow codes 5, 6 and 7 behave the same way.
- R4: Flow code 1 is a relative branch. Its condition selector `cond_i` has four codes: 0 is taken when Z=1, 1 when Z=0, 2 when C=1, and 3 when C=0. A taken branch loads PC+1 plus the sign-extended 8-bit `disp_i`, wrapping modulo 4096. A displacement of +1 therefore skips one instruction.
- R5: A branch whose condition is false loads PC+1.
- R6: Flow code 2 loads `target_i` into the PC unconditionally.
- R7: Flow code 3 (call) stores PC+1 on the return stack and loads `target_i` into the PC.
- R8: Flow code 4 (return) loads the newest stored address and removes it, so nested calls return in reverse order of entry.
- R9: The stack holds 8 addresses. A call made while all 8 are in use drops the oldest address and keeps the newest 8.
- R10: A return with an empty stack leaves the stack empty. It loads the address held in the bottom slot, which is the oldest address that was still stored when the stack last became empty, or 0x000 if nothing has been stored since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance strobe; state updates only when high |
| flow_i | input | 3 | Control-flow code (0 seq, 1 branch, 2 jump, 3 call, 4 return) |
| cond_i | input | 2 | Branch condition selector (0 Z, 1 not Z, 2 C, 3 not C) |
| flag_z_i | input | 1 | Current zero flag |
| flag_c_i | input | 1 | Current carry flag |
| disp_i | input | 8 | Signed branch displacement |
| target_i | input | 12 | Absolute jump or call address |
| pc_o | output | 12 | Current program counter |

## Verification
The bench builds the block with its default parameters: 12-bit addresses, 8-bit displacements and an 8-entry stack. With 12-bit addresses, branches and steps near 0xFFF wrap around within a handful of cycles. With an 8-entry stack, nine nested calls are enough to force the discard of the oldest address and to drain the stack into the empty-return case. A long stretch of mixed random control flow then runs against a queue-based model, covering branches, calls and returns at varying stack depths.

// File: rtl/pcseq_pkg.sv
`timescale 1ns/1ps
package pcseq_pkg;
   localparam int FLOW_W = 3;
   localparam int COND_W = 2;

   typedef enum logic [FLOW_W-1:0] {
      FLOW_SEQ    = 3'd0,
      FLOW_BRANCH = 3'd1,
      FLOW_JUMP   = 3'd2,
      FLOW_CALL   = 3'd3,
      FLOW_RET    = 3'd4
   } flow_e;

   typedef enum logic [COND_W-1:0] {
      COND_ZERO   = 2'd0,
      COND_NZERO  = 2'd1,
      COND_CARRY  = 2'd2,
      COND_NCARRY = 2'd3
   } cond_e;
endpackage

// File: rtl/pcseq_cond.sv
`timescale 1ns/1ps
module pcseq_cond
   import pcseq_pkg::*;
(
   input  logic [COND_W-1:0] sel_i,
   input  logic              z_i,
   input  logic              c_i,
   output logic              taken_o
);
   logic flag_sel;

   // bit 1 of the selector picks the flag, bit 0 inverts the sense
   always_comb begin
      flag_sel = sel_i[1] ? c_i : z_i;
      taken_o  = flag_sel ^ sel_i[0];
   end
endmodule

// File: rtl/pcseq_next.sv
`timescale 1ns/1ps
module pcseq_next
   import pcseq_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 8
)(
   input  logic              adv_i,
   input  logic [FLOW_W-1:0] flow_i,
   input  logic              taken_i,
   input  logic [DW-1:0]     disp_i,
   input  logic [AW-1:0]     target_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [AW-1:0]     pop_data_i,
   output logic [AW-1:0]     next_pc_o,
   output logic              push_o,
   output logic              pop_o,
   output logic [AW-1:0]     push_data_o
);
   localparam int EXT_W = AW - DW;

   logic [AW-1:0] seq_addr;
   logic [AW-1:0] disp_ext;
   logic [AW-1:0] rel_addr;

   always_comb begin
      seq_addr = pc_i + AW'(1);
      disp_ext = {{EXT_W{disp_i[DW-1]}}, disp_i};
      rel_addr = seq_addr + disp_ext;
   end

   always_comb begin
      next_pc_o   = pc_i;
      push_o      = 1'b0;
      pop_o       = 1'b0;
      push_data_o = seq_addr;
      if (adv_i) begin
         case (flow_i)
            FLOW_BRANCH: next_pc_o = taken_i ? rel_addr : seq_addr;
            FLOW_JUMP:   next_pc_o = target_i;
            FLOW_CALL: begin
               next_pc_o = target_i;
               push_o    = 1'b1;
            end
            FLOW_RET: begin
               next_pc_o = pop_data_i;
               pop_o     = 1'b1;
            end
            default:     next_pc_o = seq_addr;
         endcase
      end
   end
endmodule

// File: rtl/pcseq_rstack.sv
`timescale 1ns/1ps
module pcseq_rstack #(
   parameter int AW    = 12,
   parameter int DEPTH = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [AW-1:0] push_data_i,
   output logic [AW-1:0] pop_data_o
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [AW-1:0] slot_q [DEPTH];
   logic [CW-1:0] depth_q;
   logic          full;
   logic          empty;

   always_comb begin
      full  = (depth_q == FULL_CNT);
      empty = (depth_q == '0);
   end

   // newest entry sits at index depth-1; when empty, the bottom slot is read
   always_comb begin
      pop_data_o = slot_q[0];
      for (int i = 0; i < DEPTH; i++) begin
         if (CW'(i) + CW'(1) == depth_q) pop_data_o = slot_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= '0;
      end else if (push_i && !full) begin
         depth_q <= depth_q + CW'(1);
      end else if (pop_i && !empty) begin
         depth_q <= depth_q - CW'(1);
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         if (g == DEPTH - 1) begin : g_top
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  slot_q[g] <= '0;
               end else if (push_i && (full || depth_q == CW'(g))) begin
                  slot_q[g] <= push_data_i;
               end
            end
         end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  slot_q[g] <= '0;
               end else if (push_i) begin
                  if (full)                     slot_q[g] <= slot_q[g+1];
                  else if (depth_q == CW'(g))   slot_q[g] <= push_data_i;
               end
            end
         end
      end
   endgenerate

   p_one_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));
   p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      depth_q <= FULL_CNT);
   p_full_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full) |=> depth_q == FULL_CNT);
   p_push_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> pop_data_o == $past(push_data_i));
   p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty) |=> empty);
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && !pop_i) |=> $stable(depth_q));
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
   import pcseq_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          DISP_W      = 8,
   parameter int          STACK_DEPTH = 8,
   parameter logic [11:0] RESET_PC    = 12'h000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_i,
   input  logic [2:0]        flow_i,
   input  logic [1:0]        cond_i,
   input  logic              flag_z_i,
   input  logic              flag_c_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] pc_o
);
   localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

   initial begin
      assert (ADDR_W >= 2) else $error("ADDR_W must be at least 2");
      assert (DISP_W >= 1 && DISP_W < ADDR_W) else $error("DISP_W must be below ADDR_W");
      assert (STACK_DEPTH >= 1) else $error("STACK_DEPTH must be at least 1");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_d;
   logic              taken;
   logic              push;
   logic              pop;
   logic [ADDR_W-1:0] push_data;
   logic [ADDR_W-1:0] pop_data;

   pcseq_cond u_cond (
      .sel_i   (cond_i),
      .z_i     (flag_z_i),
      .c_i     (flag_c_i),
      .taken_o (taken)
   );

   pcseq_next #(.AW(ADDR_W), .DW(DISP_W)) u_next (
      .adv_i       (adv_i),
      .flow_i      (flow_i),
      .taken_i     (taken),
      .disp_i      (disp_i),
      .target_i    (target_i),
      .pc_i        (pc_q),
      .pop_data_i  (pop_data),
      .next_pc_o   (pc_d),
      .push_o      (push),
      .pop_o       (pop),
      .push_data_o (push_data)
   );

   pcseq_rstack #(.AW(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .pop_i       (pop),
      .push_data_i (push_data),
      .pop_data_o  (pop_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= PC_INIT;
      else        pc_q <= pc_d;
   end

   assign pc_o = pc_q;

   p_reset_pc_r1: assert property (@(posedge clk)
      !rst_n |-> pc_q == PC_INIT);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(pc_q));
   p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && flow_i == FLOW_SEQ) |=> pc_q == $past(pc_q) + ADDR_W'(1));
   p_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && flow_i == FLOW_BRANCH && !taken) |=> pc_q == $past(pc_q) + ADDR_W'(1));
   p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && flow_i == FLOW_JUMP) |=> pc_q == $past(target_i));
   p_call_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && flow_i == FLOW_CALL) |=> pc_q == $past(target_i));
endmodule

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_i = 1'b0;
   logic [2:0]  flow_i = '0;
   logic [1:0]  cond_i = '0;
   logic        flag_z_i = 1'b0;
   logic        flag_c_i = 1'b0;
   logic [7:0]  disp_i = '0;
   logic [11:0] target_i = '0;
   logic [11:0] pc_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int unsigned mpc = 0;
   int unsigned q[$];
   int unsigned ghost = 0;

   always #10 clk = ~clk;

   pc_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .flow_i(flow_i), .cond_i(cond_i),
      .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .disp_i(disp_i),
      .target_i(target_i), .pc_o(pc_o)
   );

   task automatic compare(input string tag, input int unsigned exp);
      n_cmp++;
      if (pc_o !== exp[11:0]) begin
         n_bad++;
         $display("FAIL %s: pc actual %03h expected %03h", tag, pc_o, exp[11:0]);
      end
   endtask

   task automatic model_reset();
      mpc = 0;
      q.delete();
      ghost = 0;
   endtask

   task automatic step(input string tag, input bit a, input int f, input int cs,
                       input bit z, input bit c, input int d, input int t);
      bit tk;
      int sd;
      adv_i = a; flow_i = 3'(f); cond_i = 2'(cs);
      flag_z_i = z; flag_c_i = c; disp_i = 8'(d); target_i = 12'(t);
      if (a) begin
         case (f)
            1: begin
               case (cs)
                  0: tk = (z == 1'b1);
                  1: tk = (z == 1'b0);
                  2: tk = (c == 1'b1);
                  default: tk = (c == 1'b0);
               endcase
               sd = (d & 255) >= 128 ? (d & 255) - 256 : (d & 255);
               if (tk) mpc = (mpc + 1 + sd) & 12'hFFF;
               else    mpc = (mpc + 1) & 12'hFFF;
            end
            2: mpc = t & 12'hFFF;
            3: begin
               if (q.size() == 8) void'(q.pop_front());
               q.push_back((mpc + 1) & 12'hFFF);
               ghost = q[0];
               mpc = t & 12'hFFF;
            end
            4: begin
               if (q.size() > 0) begin
                  mpc = q.pop_back();
                  if (q.size() > 0) ghost = q[0];
               end else begin
                  mpc = ghost;
               end
            end
            default: mpc = (mpc + 1) & 12'hFFF;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      compare(tag, mpc);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      adv_i = 1'b0;
      model_reset();
      @(negedge clk);
      compare("R1 in reset", 0);
      @(negedge clk);
      rst_n = 1'b1;
      compare("R1 after release", 0);
   endtask

   initial begin
      @(negedge clk);
      do_reset();

      // R3: sequential steps and wrap at the top of the space
      for (int i = 0; i < 4; i++) step("R3 seq", 1, 0, 0, 0, 0, 0, 0);
      step("R6 jump high", 1, 2, 0, 0, 0, 0, 12'hFFE);
      step("R3 seq", 1, 0, 0, 0, 0, 0, 0);
      step("R3 wrap", 1, 0, 0, 0, 0, 0, 0);
      for (int f = 5; f < 8; f++) step("R3 unused code", 1, f, 0, 0, 0, 0, 0);

      // R4/R5: every selector, both flag values
      for (int cs = 0; cs < 4; cs++) begin
         for (int fv = 0; fv < 2; fv++) begin
            step("R4 R5 branch +1", 1, 1, cs, fv[0], fv[0], 1, 0);
            step("R4 R5 branch -3", 1, 1, cs, fv[0], fv[0], 8'hFD, 0);
         end
      end
      step("R6 jump", 1, 2, 0, 0, 0, 0, 12'hFFE);
      step("R4 wrap forward", 1, 1, 0, 1, 0, 5, 0);
      step("R4 wrap backward", 1, 1, 2, 0, 1, 8'h80, 0);
      step("R5 not taken", 1, 1, 3, 0, 1, 8'h40, 0);

      // R2: strobe low blocks every kind of update
      step("R2 hold call", 0, 3, 0, 0, 0, 0, 12'h123);
      step("R2 hold jump", 0, 2, 0, 0, 0, 0, 12'h456);
      step("R2 hold ret", 0, 4, 0, 0, 0, 0, 0);
      step("R2 hold branch", 0, 1, 0, 1, 0, 9, 0);

      // R7/R8: nested calls unwind in reverse order
      step("R6 jump base", 1, 2, 0, 0, 0, 0, 12'h100);
      step("R7 call a", 1, 3, 0, 0, 0, 0, 12'h200);
      step("R3 seq", 1, 0, 0, 0, 0, 0, 0);
      step("R7 call b", 1, 3, 0, 0, 0, 0, 12'h300);
      step("R2 hold call", 0, 3, 0, 0, 0, 0, 12'h777);
      step("R7 call c", 1, 3, 0, 0, 0, 0, 12'h400);
      step("R8 ret c", 1, 4, 0, 0, 0, 0, 0);
      step("R8 ret b", 1, 4, 0, 0, 0, 0, 0);
      step("R8 ret a", 1, 4, 0, 0, 0, 0, 0);

      // R9/R10: overflow by one, drain, then return from empty
      for (int i = 0; i < 9; i++) step("R9 deep call", 1, 3, 0, 0, 0, 0, 12'h010 * (i + 1));
      for (int i = 0; i < 8; i++) step("R9 R8 unwind", 1, 4, 0, 0, 0, 0, 0);
      step("R10 empty ret", 1, 4, 0, 0, 0, 0, 0);
      step("R10 empty ret again", 1, 4, 0, 0, 0, 0, 0);
      step("R7 call after empty", 1, 3, 0, 0, 0, 0, 12'h555);
      step("R8 ret after empty", 1, 4, 0, 0, 0, 0, 0);

      // R1: reset mid-run clears PC and stack
      step("R7 call pre-reset", 1, 3, 0, 0, 0, 0, 12'h321);
      do_reset();
      step("R1 ret after reset", 1, 4, 0, 0, 0, 0, 0);

      // mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         int f;
         f = $urandom_range(0, 9);
         if (f > 4) f = (f == 9) ? $urandom_range(5, 7) : (f % 5);
         step("R3 R4 R7 R8 R9 random", ($urandom_range(0, 7) != 0), f,
              $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1),
              $urandom_range(0, 255), $urandom_range(0, 4095));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule